// File: doc/BRIEF.md
# Systolic Interval Cost Array

This block evaluates the minimum-cost interval recurrence c(i,j) = w(i,j) + min over i<k<j of (c(i,k) + c(k,j)). That recurrence drives optimal binary search tree construction and optimal parenthesization of a string of N items. It is built as a triangle of N(N+1)/2 identical cells. Cell (i,j), with 0 <= i < j <= N, stands for the interval of items i..j-1. Each cell passes values only to its right neighbour (i,j+1) and its upper neighbour (i-1,j).

Every cell keeps its own weight, a running minimum and two belts per direction. The fast belt moves a finished cost one cell per cycle. The slow belt has two stages per cell and moves one cell every two cycles. A cell whose interval spans t items publishes its cost on both fast belts at time 2t. If t is even, the cell also copies the passing fast value onto its slow belts at time 3t/2. With this timing the two halves of every split k meet in the same cell in the same cycle. One near half arrives on a fast belt and the matching far half arrives on a slow belt.

Weights are written one at a time while the array is idle. A start pulse launches the run. After 2N cycles the corner cell (0,N) presents c(0,N) with a one-cycle done flag. All arithmetic saturates at the largest word value.

Top module: `ivdp_array`

## Requirements
- R1: After reset `done` is low and `result` reads 0xFFFF, the largest 16-bit value.
- R2: A write with `wr_en` high stores `wr_data` as the weight of cell (`wr_row`,`wr_col`) when `wr_row` < `wr_col` <= N. A write to any other address changes no weight and so has no effect on any later result.
- R3: A single-item interval (i,i+1) costs exactly its own weight. With all longer-interval weights zero, the corner result is the sum of the single-item weights.
- R4: When `done` is high, `result` equals c(0,N) as defined by the recurrence above, using the most recently written weights.
- R5: If `start` is sampled high at clock edge E, `done` is high for exactly the one cycle that follows edge E+2N.
- R6: Between `done` and the next `start`, `result` holds its value.
- R7: Every sum saturates at 0xFFFF and never wraps around. A run whose true cost exceeds 0xFFFF returns 0xFFFF.
- R8: A `start` during a run abandons that run. The array restarts, and `done` appears only 2N cycles after the last `start`.
- R9: Each start clears all partial costs and belt contents. A run's result therefore depends only on the current weights and not on any earlier run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Weight write strobe |
| wr_row | input | clog2(N+1) | Left end i of the interval being written |
| wr_col | input | clog2(N+1) | Right end j (exclusive) of the interval being written |
| wr_data | input | 16 | Weight value |
| start | input | 1 | Launches a run (and clears the previous one) |
| result | output | 16 | Cost of the whole string, c(0,N) |
| done | output | 1 | One-cycle flag marking `result` valid |

## Verification
The bench checks the corner output against a plain software recurrence. It uses the ascending-item parenthesization case, random weights and singleton-only weights. A belt with its slow stage tapped at the wrong place, or a fork at the wrong cycle, pairs c(i,k) with some c(k',j) where k' != k. Such a design returns a cost below or above the reference. An all-large weight set goes after wrap-around: a non-saturating adder returns a small wrong cost instead of 0xFFFF. A restart in mid-run, and a small-weight run that directly follows a saturated run, catch state left over from an earlier run. An off-by-one timer moves `done` away from cycle 2N.

// File: rtl/ivdp_pkg.sv
package ivdp_pkg;
  localparam int unsigned WORD_W = 16;
  typedef logic [WORD_W-1:0] word_t;
  localparam word_t WORD_MAX = '1;

  // one direction of a link: fast lane and slow lane (second stage)
  typedef struct packed {
    word_t fast;
    word_t slow;
  } link_t;

  localparam link_t LINK_IDLE = '{fast: WORD_MAX, slow: WORD_MAX};

  function automatic word_t sat_add(input word_t a, input word_t b);
    logic [WORD_W:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[WORD_W] ? WORD_MAX : s[WORD_W-1:0];
  endfunction

  function automatic word_t min2(input word_t a, input word_t b);
    return (a < b) ? a : b;
  endfunction
endpackage

// File: rtl/ivdp_timer.sv
module ivdp_timer #(
  parameter int unsigned LAST = 12,
  parameter int unsigned TW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          run,
  output logic [TW-1:0] tnow,
  output logic          shift_en,
  output logic          done
);
  localparam logic [TW-1:0] LAST_T = TW'(LAST);

  logic          run_q, run_d;
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (start) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q && cnt_q != LAST_T) begin
      cnt_d = cnt_q + 1'b1;
    end else if (run_q) begin
      run_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign run      = run_q;
  assign tnow     = cnt_q;
  assign shift_en = run_q && (cnt_q != LAST_T);
  assign done     = run_q && (cnt_q == LAST_T);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R5
  tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !start) |=> (cnt_q == $past(cnt_q) + 1'b1));
  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (run_q && cnt_q == '0 && !done));
endmodule

// File: rtl/ivdp_cell.sv
module ivdp_cell
  import ivdp_pkg::*;
#(
  parameter int unsigned DIST = 1,
  parameter int unsigned TW   = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          shift_en,
  input  logic [TW-1:0] tnow,
  input  logic          wr_hit,
  input  word_t         wr_data,
  input  link_t         h_in,
  input  link_t         v_in,
  output link_t         h_out,
  output link_t         v_out
);
  localparam logic [TW-1:0] T_EMIT = TW'(2 * DIST - 1);
  localparam logic [TW-1:0] T_FORK = TW'((3 * DIST) / 2 - 1);
  localparam bit            FORKS  = (DIST % 2 == 0);

  word_t w_q, w_d, acc_q, acc_d;
  word_t hf_q, hf_d, hs1_q, hs1_d, hs2_q, hs2_d;
  word_t vf_q, vf_d, vs1_q, vs1_d, vs2_q, vs2_d;
  word_t pair_a, pair_b, best, own;
  logic  emit, fork_now, reg_en;

  always_comb begin
    pair_a   = sat_add(hf_q, vs1_q);
    pair_b   = sat_add(hs1_q, vf_q);
    best     = min2(acc_q, min2(pair_a, pair_b));
    own      = (DIST == 1) ? w_q : sat_add(w_q, best);
    emit     = (tnow == T_EMIT);
    fork_now = FORKS && (tnow == T_FORK);
    w_d      = wr_hit ? wr_data : w_q;
    reg_en   = clr || shift_en;
    if (clr) begin
      acc_d = WORD_MAX;
      hf_d  = WORD_MAX; hs1_d = WORD_MAX; hs2_d = WORD_MAX;
      vf_d  = WORD_MAX; vs1_d = WORD_MAX; vs2_d = WORD_MAX;
    end else begin
      acc_d = best;
      hf_d  = emit ? own : h_in.fast;
      vf_d  = emit ? own : v_in.fast;
      hs1_d = fork_now ? h_in.fast : h_in.slow;
      vs1_d = fork_now ? v_in.fast : v_in.slow;
      hs2_d = hs1_q;
      vs2_d = vs1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_q   <= '0;
      acc_q <= WORD_MAX;
      hf_q  <= WORD_MAX; hs1_q <= WORD_MAX; hs2_q <= WORD_MAX;
      vf_q  <= WORD_MAX; vs1_q <= WORD_MAX; vs2_q <= WORD_MAX;
    end else begin
      w_q <= w_d;
      if (reg_en) begin
        acc_q <= acc_d;
        hf_q  <= hf_d;  hs1_q <= hs1_d; hs2_q <= hs2_d;
        vf_q  <= vf_d;  vs1_q <= vs1_d; vs2_q <= vs2_d;
      end
    end
  end

  assign h_out = '{fast: hf_q, slow: hs2_q};
  assign v_out = '{fast: vf_q, slow: vs2_q};

  // R4
  acc_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr) |=> (acc_q <= $past(acc_q)));
  // R7
  emit_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !clr && emit) |=> (hf_q >= $past(w_q)));
endmodule

// File: rtl/ivdp_array.sv
module ivdp_array
  import ivdp_pkg::*;
#(
  parameter int unsigned N  = 6,
  localparam int unsigned IW = $clog2(N + 1),
  localparam int unsigned TW = $clog2(2 * N + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_row,
  input  logic [IW-1:0]     wr_col,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              start,
  output logic [WORD_W-1:0] result,
  output logic              done
);
  logic [1:0]    rst_sync;
  logic          rst_s;
  logic          run, shift_en;
  logic [TW-1:0] tnow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  ivdp_timer #(.LAST(2 * N), .TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_s), .start(start), .run(run),
    .tnow(tnow), .shift_en(shift_en), .done(done)
  );

  link_t h_bus [N][N+1];
  link_t v_bus [N][N+1];

  for (genvar gi = 0; gi < N; gi++) begin : g_row
    for (genvar gj = 0; gj <= N; gj++) begin : g_col
      if (gj > gi) begin : g_cell
        link_t hin, vin;
        if (gj - 1 > gi) begin : g_hl
          assign hin = h_bus[gi][gj-1];
        end else begin : g_he
          assign hin = LINK_IDLE;
        end
        if (gi + 1 < gj) begin : g_vb
          assign vin = v_bus[gi+1][gj];
        end else begin : g_ve
          assign vin = LINK_IDLE;
        end
        ivdp_cell #(.DIST(gj - gi), .TW(TW)) u_cell (
          .clk(clk), .rst_n(rst_s), .clr(start), .shift_en(shift_en),
          .tnow(tnow),
          .wr_hit(wr_en && wr_row == IW'(gi) && wr_col == IW'(gj)),
          .wr_data(wr_data), .h_in(hin), .v_in(vin),
          .h_out(h_bus[gi][gj]), .v_out(v_bus[gi][gj])
        );
      end else begin : g_void
        assign h_bus[gi][gj] = LINK_IDLE;
        assign v_bus[gi][gj] = LINK_IDLE;
      end
    end
  end

  assign result = h_bus[0][N].fast;

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (!run && !start) |=> $stable(result));
endmodule

// File: tb/test_ivdp_array.sv
`timescale 1ns/1ps
module test_ivdp_array;
  localparam int N    = 6;
  localparam int IW   = $clog2(N + 1);
  localparam int MAXV = 65535;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          start = 1'b0;
  logic [IW-1:0] wr_row = '0;
  logic [IW-1:0] wr_col = '0;
  logic [15:0]   wr_data = '0;
  logic [15:0]   result;
  logic          done;

  always #2 clk = ~clk;

  ivdp_array #(.N(N)) i_ivdp_array (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_row(wr_row),
    .wr_col(wr_col), .wr_data(wr_data), .start(start),
    .result(result), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  int last_val = 0;
  int wt [0:N][0:N];

  typedef struct {
    int    val;
    int    edge_no;
    string req;
  } exp_t;
  exp_t sb [$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sat(input int x);
    return (x > MAXV) ? MAXV : x;
  endfunction

  function automatic int ref_cost();
    int c [0:N][0:N];
    for (int a = 0; a <= N; a++)
      for (int b = 0; b <= N; b++) c[a][b] = 0;
    for (int len = 1; len <= N; len++) begin
      for (int a = 0; a + len <= N; a++) begin
        int b = a + len;
        if (len == 1) c[a][b] = sat(wt[a][b]);
        else begin
          int best = MAXV;
          for (int k = a + 1; k < b; k++)
            if (sat(c[a][k] + c[k][b]) < best) best = sat(c[a][k] + c[k][b]);
          c[a][b] = sat(wt[a][b] + best);
        end
      end
    end
    return c[0][N];
  endfunction

  task automatic put_w(input int r, input int cl, input int v);
    @(negedge clk);
    wr_en = 1'b1; wr_row = IW'(r); wr_col = IW'(cl); wr_data = 16'(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic load_all();
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b <= N; b++) put_w(a, b, wt[a][b]);
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // driver: launch a run and push the expected item
  task automatic launch(input string req);
    exp_t e;
    pulse_start();
    e.val = ref_cost();
    e.edge_no = cyc + 2 * N;
    e.req = req;
    sb.push_back(e);
    wait (sb.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  // monitor: compare each finished run
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) check(1'b0, "R8 unexpected done", 1, 0);
      else begin
        exp_t e;
        e = sb.pop_front();
        check(int'(result) == e.val, e.req, int'(result), e.val);
        check(cyc == e.edge_no, "R5 done cycle", cyc, e.edge_no);
        last_val = e.val;
      end
    end
  end

  task automatic set_random(input int hi);
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b <= N; b++) wt[a][b] = $urandom_range(0, hi);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int a = 0; a <= N; a++)
      for (int b = 0; b <= N; b++) wt[a][b] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(int'(result) == MAXV, "R1 result", int'(result), MAXV);
    check(done == 1'b0, "R1 done", int'(done), 0);

    // R4 ascending items, cost = sum of enclosed items
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b <= N; b++) begin
        int s = 0;
        for (int h = a; h < b; h++) s += h + 1;
        wt[a][b] = (b - a == 1) ? 0 : s;
      end
    load_all();
    launch("R4 item sums");

    // R6 result holds after done
    repeat (6) @(negedge clk);
    check(int'(result) == last_val, "R6 hold", int'(result), last_val);
    check(done == 1'b0, "R5 done low after pulse", int'(done), 0);

    // R3 singleton weights only
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b <= N; b++)
        wt[a][b] = (b - a == 1) ? $urandom_range(1, 500) : 0;
    load_all();
    launch("R3 singleton sum");

    // R4 random weights
    for (int r = 0; r < 3; r++) begin
      set_random(200);
      load_all();
      launch("R4 random");
    end

    // R2 writes to non-cell addresses are ignored
    set_random(300);
    load_all();
    put_w(3, 3, 0);
    put_w(4, 2, 0);
    put_w(7, 7, 0);
    put_w(6, 1, 0);
    launch("R2 stray writes");

    // R7 saturation
    for (int a = 0; a < N; a++)
      for (int b = a + 1; b <= N; b++) wt[a][b] = 16'h9000;
    load_all();
    launch("R7 saturate");

    // R9 small run right after a saturated one
    set_random(50);
    load_all();
    launch("R9 fresh run");

    // R8 restart in mid-run
    set_random(120);
    load_all();
    pulse_start();
    repeat (3) @(negedge clk);
    launch("R8 restart");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule